// File: doc/BRIEF.md
# Low-Power Wakeup Control Unit

This unit sits between a processor, an interrupt controller and the clock-control logic of a chip. Software writes an 8-bit control word over a simple register bus. The word holds an entry enable and a wake priority threshold. When the processor reports that it has halted and entry is enabled, the unit asks the external clock logic to enter low-power mode.

While the chip sleeps, the unit watches the highest pending unmasked interrupt priority. The interrupt controller reports that priority together with a valid flag. If the pending priority is strictly above the threshold that was in force at entry, the unit raises an exit request so that the clock logic can restore the clocks. The exit decision is combinational from the interrupt inputs, so it does not wait for a clock edge that may be gated off. The exit request stays up until the processor withdraws its halted indication. The unit then returns to its running state.

Control word layout: bit 7 is the entry enable, bits 3:0 are the wake threshold (0 to 15), and bits 6:4 always read as zero.

Top module: `lpwake_ctrl`

## Requirements
- R1: After reset, `cfg_rdata` reads 0x00, and both `lp_enter` and `lp_exit` are low. Low-power entry is therefore disabled.
- R2: A write (`cfg_wr` high at a clock edge) stores bit 7 as the enable and bits 3:0 as the threshold. From the next cycle, `cfg_rdata` shows `{en,3'b000,thr}`, and bits 6:4 read as zero whatever was written.
- R3: `lp_enter` rises in the cycle after an edge at which `cpu_halted` is high and the enable bit is set. If the enable is clear, `lp_enter` stays low however long `cpu_halted` is held.
- R4: While low power is requested, `irq_valid` high with `irq_prio` strictly greater than the captured threshold raises `lp_exit` and drops `lp_enter` in the same cycle, with no clock edge needed.
- R5: While low power is requested, a pending priority equal to or below the threshold, or any priority with `irq_valid` low, leaves `lp_enter` high and `lp_exit` low.
- R6: Once raised, `lp_exit` stays high while `cpu_halted` stays high, even if the interrupt goes away. It falls after the first edge at which `cpu_halted` is low.
- R7: The threshold is captured at entry. A register write made during low power shows on `cfg_rdata` at once, but it does not change the wake decision until the next entry.
- R8: If `cpu_halted` drops while low power is requested and no wake has occurred, `lp_enter` falls after the next edge and `lp_exit` stays low.
- R9: `lp_enter` and `lp_exit` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_wdata | input | 8 | Register write data |
| cfg_rdata | output | 8 | Register read data |
| cpu_halted | input | 1 | Processor has stopped executing |
| irq_valid | input | 1 | An unmasked interrupt is pending |
| irq_prio | input | 4 | Highest pending unmasked priority |
| lp_enter | output | 1 | Request to enter low-power mode |
| lp_exit | output | 1 | Request to leave low-power mode |

## Verification
The assertions assume that the interrupt inputs are settled before each clock edge, and that `cpu_halted` is a level that the processor holds until it sees the exit request. They also assume that register writes are single-cycle strobes. The bench drives every input shortly after a rising edge and holds it for the full cycle. It raises `cpu_halted` only when a scenario wants an entry, and drops it only after it has checked `lp_exit`. The combinational wake path is probed within the same cycle, after the inputs have settled.

// File: rtl/lpwake_pkg.sv
// Package: shared widths, bit positions and sequencer state encoding for
// the low-power wakeup control unit. Assumes an 8-bit control word.
package lpwake_pkg;
    localparam int REG_W  = 8;
    localparam int PRIO_W = 4;
    localparam int EN_BIT = 7;

    typedef enum logic [1:0] {
        ST_RUN  = 2'd0,
        ST_LP   = 2'd1,
        ST_EXIT = 2'd2
    } lp_state_t;
endpackage

// File: rtl/lpwake_cfg_reg.sv
// Control word register. Holds the entry enable and the wake threshold.
// Unused bits are not stored and read as zero.
// Assumes: write strobe is synchronous to clk; reset is synchronous, active-low.
module lpwake_cfg_reg #(
    parameter int REG_W  = 8,
    parameter int PRIO_W = 4,
    parameter int EN_BIT = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [REG_W-1:0]  wdata,
    output logic              en,
    output logic [PRIO_W-1:0] thr,
    output logic [REG_W-1:0]  rdata
);
    localparam int ZW = EN_BIT - PRIO_W;

    // Capture enable and threshold fields on a write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en  <= 1'b0;
            thr <= '0;
        end else if (wr) begin
            en  <= wdata[EN_BIT];
            thr <= wdata[PRIO_W-1:0];
        end
    end

    // Assemble read view with reserved bits at zero.
    always_comb begin
        rdata = '0;
        rdata[EN_BIT] = en;
        rdata[PRIO_W-1:0] = thr;
        rdata[EN_BIT-1:PRIO_W] = {ZW{1'b0}};
    end

    p_wr_takes_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr |=> (rdata == {$past(wdata[EN_BIT]), {ZW{1'b0}}, $past(wdata[PRIO_W-1:0])}));
endmodule

// File: rtl/lpwake_cmp.sv
// Wake comparator. Purely combinational, so it works while clocks are gated.
// Reports a hit when a valid pending priority strictly exceeds the threshold.
// Assumes: irq_prio is meaningful only when irq_valid is high.
module lpwake_cmp #(
    parameter int PRIO_W = 4
) (
    input  logic              irq_valid,
    input  logic [PRIO_W-1:0] irq_prio,
    input  logic [PRIO_W-1:0] thr,
    output logic              hit
);
    // Strict-greater comparison qualified by valid.
    always_comb hit = irq_valid && (irq_prio > thr);
endmodule

// File: rtl/lpwake_seq.sv
// Entry/exit sequencer. RUN -> LP when halted and enabled, capturing the
// threshold. LP -> EXIT on a wake hit, or LP -> RUN if halt is withdrawn.
// EXIT -> RUN when halt drops. Exit is raised combinationally from the hit.
// Assumes: cpu_halted is held until the exit request is seen.
module lpwake_seq
    import lpwake_pkg::*;
#(
    parameter int PRIO_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_halted,
    input  logic              cfg_en,
    input  logic [PRIO_W-1:0] cfg_thr,
    input  logic              wake_hit,
    output logic [PRIO_W-1:0] thr_cap,
    output logic              lp_enter,
    output logic              lp_exit
);
    lp_state_t state, state_nx;
    logic      wake_now;

    // Wake is live only while sleeping.
    always_comb wake_now = (state == ST_LP) && wake_hit;

    // Next-state selection.
    always_comb begin
        state_nx = state;
        case (state)
            ST_RUN:  if (cpu_halted && cfg_en) state_nx = ST_LP;
            ST_LP:   if (wake_hit)              state_nx = ST_EXIT;
                     else if (!cpu_halted)      state_nx = ST_RUN;
            ST_EXIT: if (!cpu_halted)           state_nx = ST_RUN;
            default:                            state_nx = ST_RUN;
        endcase
    end

    // State register and threshold capture at entry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_RUN;
            thr_cap <= '0;
        end else begin
            state <= state_nx;
            if (state == ST_RUN && state_nx == ST_LP) thr_cap <= cfg_thr;
        end
    end

    // Handshake outputs; enter yields to exit.
    always_comb begin
        lp_exit  = (state == ST_EXIT) || wake_now;
        lp_enter = (state == ST_LP) && !wake_now;
    end

    p_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(lp_enter && lp_exit));
    p_enter_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lp_enter) |-> $past(cpu_halted) && $past(cfg_en));
    p_exit_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (lp_exit && cpu_halted) |=> lp_exit);
    p_thr_stable_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_LP && $past(state) == ST_LP) |-> $stable(thr_cap));
    p_abort_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (lp_enter && !cpu_halted) |=> !lp_enter && !lp_exit);
endmodule

// File: rtl/lpwake_ctrl.sv
// Top of the low-power wakeup control unit: control register, wake
// comparator on the captured threshold, and the entry/exit sequencer.
// Assumes: single clock domain, synchronous active-low reset.
module lpwake_ctrl
    import lpwake_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic [REG_W-1:0]  cfg_wdata,
    output logic [REG_W-1:0]  cfg_rdata,
    input  logic              cpu_halted,
    input  logic              irq_valid,
    input  logic [PRIO_W-1:0] irq_prio,
    output logic              lp_enter,
    output logic              lp_exit
);
    logic              en_w;
    logic [PRIO_W-1:0] thr_w;
    logic [PRIO_W-1:0] thr_cap_w;
    logic              hit_w;

    lpwake_cfg_reg #(.REG_W(REG_W), .PRIO_W(PRIO_W), .EN_BIT(EN_BIT)) u_cfg (
        .clk(clk), .rst_n(rst_n), .wr(cfg_wr), .wdata(cfg_wdata),
        .en(en_w), .thr(thr_w), .rdata(cfg_rdata)
    );

    lpwake_cmp #(.PRIO_W(PRIO_W)) u_cmp (
        .irq_valid(irq_valid), .irq_prio(irq_prio), .thr(thr_cap_w), .hit(hit_w)
    );

    lpwake_seq #(.PRIO_W(PRIO_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .cpu_halted(cpu_halted),
        .cfg_en(en_w), .cfg_thr(thr_w), .wake_hit(hit_w),
        .thr_cap(thr_cap_w), .lp_enter(lp_enter), .lp_exit(lp_exit)
    );

    p_exit_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lp_exit) |-> irq_valid && (irq_prio > thr_cap_w));
endmodule

// File: tb/lpwake_ctrl_tb.sv
module lpwake_ctrl_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_wr = 1'b0;
    logic [7:0] cfg_wdata = '0;
    logic [7:0] cfg_rdata;
    logic       cpu_halted = 1'b0;
    logic       irq_valid = 1'b0;
    logic [3:0] irq_prio = '0;
    logic       lp_enter, lp_exit;
    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    lpwake_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .cpu_halted(cpu_halted), .irq_valid(irq_valid),
        .irq_prio(irq_prio), .lp_enter(lp_enter), .lp_exit(lp_exit)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Advance one edge; inputs change 2 ns after it.
    task automatic step();
        @(posedge clk); #2;
    endtask

    task automatic wr(input logic [7:0] v);
        cfg_wr = 1'b1; cfg_wdata = v; step(); cfg_wr = 1'b0;
    endtask

    task automatic outs(input string req, input logic en, input logic ex);
        #1;
        chk(req, {7'b0, lp_enter}, {7'b0, en});
        chk(req, {7'b0, lp_exit},  {7'b0, ex});
    endtask

    task automatic t_reset();
        step(); step(); rst_n = 1'b1; step();
        chk("R1", cfg_rdata, 8'h00);
        outs("R1", 1'b0, 1'b0);
    endtask

    task automatic t_reg();
        wr(8'hFA); #1; chk("R2", cfg_rdata, 8'h8A);
        wr(8'h73); #1; chk("R2", cfg_rdata, 8'h03);
    endtask

    task automatic t_no_enable();
        cpu_halted = 1'b1;
        for (int i = 0; i < 4; i++) step();
        outs("R3 disabled", 1'b0, 1'b0);
        cpu_halted = 1'b0; step();
    endtask

    task automatic t_wake_strict();
        wr(8'h85);
        cpu_halted = 1'b1; step();
        outs("R3 enter", 1'b1, 1'b0);
        irq_valid = 1'b0; irq_prio = 4'hF; outs("R5 invalid", 1'b1, 1'b0);
        irq_valid = 1'b1; irq_prio = 4'h5; outs("R5 equal", 1'b1, 1'b0);
        irq_prio = 4'h2; outs("R5 below", 1'b1, 1'b0);
        step(); outs("R5 stays", 1'b1, 1'b0);
        irq_prio = 4'h6; outs("R4 wake", 1'b0, 1'b1);
        step(); irq_valid = 1'b0; irq_prio = 4'h0;
        outs("R6 held", 1'b0, 1'b1);
        step(); outs("R6 held2", 1'b0, 1'b1);
        cpu_halted = 1'b0; outs("R6 before edge", 1'b0, 1'b1);
        step(); outs("R6 released", 1'b0, 1'b0);
    endtask

    task automatic t_capture();
        wr(8'h83);
        cpu_halted = 1'b1; step();
        outs("R7 enter", 1'b1, 1'b0);
        wr(8'h8F); #1; chk("R7 readback", cfg_rdata, 8'h8F);
        irq_valid = 1'b1; irq_prio = 4'h4; outs("R7 old thr", 1'b0, 1'b1);
        irq_valid = 1'b0; cpu_halted = 1'b0; step(); step();
        cpu_halted = 1'b1; step();
        irq_valid = 1'b1; irq_prio = 4'hF; outs("R7 new thr", 1'b1, 1'b0);
        irq_valid = 1'b0;
    endtask

    task automatic t_abort();
        cpu_halted = 1'b0; outs("R8 pre", 1'b1, 1'b0);
        step(); outs("R8 abort", 1'b0, 1'b0);
        step(); outs("R8 run", 1'b0, 1'b0);
    endtask

    initial begin
        t_reset();
        t_reg();
        t_no_enable();
        t_wake_strict();
        t_capture();
        t_abort();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(8 * 200000);
        errors++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule